// File: doc/BRIEF.md
# Two-Port Semaphore Token Bank

This block holds a bank of binary lock tokens shared by two processor ports, called left and right. It is kept apart from any data storage. A processor claims a token by writing a 0 to it. It then reads the token back to learn whether the claim succeeded. Writing a 1 gives the token up. Each token remembers a separate request from each side. If one side asks while the other side holds the token, the request waits. When the holder lets go, the token moves straight to the waiting side.

Flags are active low and are seen from the reader's side. The holder reads all zeros and the other side reads all ones. A read value is captured when the read begins. It then stays frozen until the read ends, so a token cannot change under a processor in the middle of a read.

Each token runs its own state machine. The states are:
- `TK_FREE`: no side holds or wants the token.
- `TK_LEFT`: left holds the token and right is not waiting.
- `TK_RIGHT`: right holds the token and left is not waiting.
- `TK_LEFT_RWAIT`: left holds the token and right is waiting.
- `TK_RIGHT_LWAIT`: right holds the token and left is waiting.

The transitions are:
- Claim: `TK_FREE` goes to `TK_LEFT` or `TK_RIGHT`.
- Tie: `TK_FREE` goes to `TK_LEFT_RWAIT` when both sides claim in the same cycle.
- Queue: a holding state goes to its waiting variant when the other side claims.
- Release: `TK_LEFT` or `TK_RIGHT` goes to `TK_FREE`.
- Hand-off: a waiting state goes to the waiter's plain holding state when the holder releases.
- Withdraw: a waiting state goes back to the plain holding state when the waiter writes 1.
- Double release: a waiting state goes to `TK_FREE` when both sides write 1 together.

Top module: `token_lock_bank`

## Requirements
- R1: After reset every token is free, and each port's read data is 9'h1FF.
- R2: The 3-bit address picks one of eight tokens. An access to one token leaves every other token unchanged.
- R3: A write uses data bit 0 only. Bit 0 = 0 is a claim and bit 0 = 1 is a release, whatever bits 8..1 hold.
- R4: A claim on a free token makes the claiming side read 0 from that token. The other side reads 1 for as long as the claim holds.
- R5: A claim from the side that does not hold the token is kept pending. When the holder releases, the token passes to the pending side without a further write.
- R6: A side stops holding a token only when it writes 1 to that token. A 1 written by a side that neither holds nor waits for the token has no effect.
- R7: A read returns the token's flag copied onto all 9 data bits: 9'h000 if held by the reader, else 9'h1FF.
- R8: A read is active while select and output enable are 1 and read/write is 0. Read data is captured at the first clock edge of an active read, and it stays frozen until the read goes inactive.
- R9: When both sides claim a free token in different cycles, the earlier claimer gets it.
- R10: Simultaneous claims on a free token grant it to left. Right's claim stays pending and gets the token when left releases.
- R11: A claim written by the side that already holds the token leaves the token state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lt_sel | input | 1 | Left semaphore select |
| lt_wr | input | 1 | Left read/write: 1 = write, 0 = read |
| lt_oe | input | 1 | Left output enable |
| lt_addr | input | 3 | Left token address |
| lt_wdata | input | 9 | Left write data; only bit 0 is used |
| lt_rdata | output | 9 | Left captured read data |
| rt_sel | input | 1 | Right semaphore select |
| rt_wr | input | 1 | Right read/write: 1 = write, 0 = read |
| rt_oe | input | 1 | Right output enable |
| rt_addr | input | 3 | Right token address |
| rt_wdata | input | 9 | Right write data; only bit 0 is used |
| rt_rdata | output | 9 | Right captured read data |

## Verification
A token state machine in the wrong state shows up as a wrong flag on the next read that starts after the faulty edge. Typical faults are a dropped pending claim, a lost hand-off or a wrong tie winner. These appear one cycle after the read is raised, either as both sides reading 0 or as the expected holder reading 1. A faulty read latch shows up in a different way. Read data changes while a read is held, even though the token changed state during that read. The bench therefore holds reads open across hand-offs, not only across single-cycle reads.

// File: rtl/token_lock_pkg.sv
package token_lock_pkg;

    typedef enum logic [2:0] {
        TK_FREE,
        TK_LEFT,
        TK_RIGHT,
        TK_LEFT_RWAIT,
        TK_RIGHT_LWAIT
    } tok_state_t;

endpackage

// File: rtl/token_fsm.sv
module token_fsm
    import token_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lt_we,
    input  logic lt_bit,
    input  logic rt_we,
    input  logic rt_bit,
    output logic lt_owns,
    output logic rt_owns
);

    tok_state_t state, state_nx;

    logic lt_claim, lt_free, rt_claim, rt_free;
    assign lt_claim = lt_we & ~lt_bit;
    assign lt_free  = lt_we &  lt_bit;
    assign rt_claim = rt_we & ~rt_bit;
    assign rt_free  = rt_we &  rt_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TK_FREE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TK_FREE: begin
                if (lt_claim && rt_claim) state_nx = TK_LEFT_RWAIT;
                else if (lt_claim)        state_nx = TK_LEFT;
                else if (rt_claim)        state_nx = TK_RIGHT;
            end
            TK_LEFT: begin
                if (lt_free)       state_nx = rt_claim ? TK_RIGHT : TK_FREE;
                else if (rt_claim) state_nx = TK_LEFT_RWAIT;
            end
            TK_RIGHT: begin
                if (rt_free)       state_nx = lt_claim ? TK_LEFT : TK_FREE;
                else if (lt_claim) state_nx = TK_RIGHT_LWAIT;
            end
            TK_LEFT_RWAIT: begin
                if (lt_free && rt_free) state_nx = TK_FREE;
                else if (lt_free)       state_nx = TK_RIGHT;
                else if (rt_free)       state_nx = TK_LEFT;
            end
            TK_RIGHT_LWAIT: begin
                if (lt_free && rt_free) state_nx = TK_FREE;
                else if (rt_free)       state_nx = TK_LEFT;
                else if (lt_free)       state_nx = TK_RIGHT;
            end
            default: state_nx = TK_FREE;
        endcase
    end

    always_comb begin
        lt_owns = (state == TK_LEFT)  || (state == TK_LEFT_RWAIT);
        rt_owns = (state == TK_RIGHT) || (state == TK_RIGHT_LWAIT);
    end

    assert_tie_left_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TK_FREE && lt_claim && rt_claim) |=> (state == TK_LEFT_RWAIT));

    assert_handoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TK_LEFT_RWAIT && lt_free && !rt_free) |=> rt_owns);

    assert_keep_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_owns && !lt_free) |=> lt_owns);

    assert_reclaim_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TK_RIGHT && rt_claim && !lt_we) |=> (state == TK_RIGHT));

endmodule

// File: rtl/token_port.sv
module token_port #(
    parameter int AW = 3,
    parameter int DW = 9,
    localparam int NT = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr,
    input  logic          oe,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NT-1:0] owns,
    output logic [NT-1:0] we_vec,
    output logic          wbit,
    output logic [DW-1:0] rdata
);

    logic rd_on, rd_prev;
    logic unused_hi;

    assign rd_on     = sel & oe & ~wr;
    assign wbit      = wdata[0];
    assign unused_hi = ^wdata[DW-1:1];

    always_comb begin
        we_vec = '0;
        if (sel && wr) we_vec[addr] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev <= 1'b0;
            rdata   <= {DW{1'b1}};
        end else begin
            rd_prev <= rd_on;
            if (rd_on && !rd_prev) rdata <= {DW{~owns[addr]}};
        end
    end

    assert_read_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_on && rd_prev) |=> $stable(rdata));

    assert_replicated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(rdata) == 0) || ($countones(rdata) == DW));

endmodule

// File: rtl/token_lock_bank.sv
module token_lock_bank #(
    parameter int AW = 3,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lt_sel,
    input  logic          lt_wr,
    input  logic          lt_oe,
    input  logic [AW-1:0] lt_addr,
    input  logic [DW-1:0] lt_wdata,
    output logic [DW-1:0] lt_rdata,
    input  logic          rt_sel,
    input  logic          rt_wr,
    input  logic          rt_oe,
    input  logic [AW-1:0] rt_addr,
    input  logic [DW-1:0] rt_wdata,
    output logic [DW-1:0] rt_rdata
);

    localparam int NT = 1 << AW;

    logic [NT-1:0] lt_we, rt_we, lt_owns, rt_owns;
    logic          lt_bit, rt_bit;

    token_port #(.AW(AW), .DW(DW)) u_lt_port (
        .clk(clk), .rst_n(rst_n), .sel(lt_sel), .wr(lt_wr), .oe(lt_oe),
        .addr(lt_addr), .wdata(lt_wdata), .owns(lt_owns),
        .we_vec(lt_we), .wbit(lt_bit), .rdata(lt_rdata)
    );

    token_port #(.AW(AW), .DW(DW)) u_rt_port (
        .clk(clk), .rst_n(rst_n), .sel(rt_sel), .wr(rt_wr), .oe(rt_oe),
        .addr(rt_addr), .wdata(rt_wdata), .owns(rt_owns),
        .we_vec(rt_we), .wbit(rt_bit), .rdata(rt_rdata)
    );

    for (genvar i = 0; i < NT; i++) begin : g_tok
        token_fsm u_tok (
            .clk(clk), .rst_n(rst_n),
            .lt_we(lt_we[i]), .lt_bit(lt_bit),
            .rt_we(rt_we[i]), .rt_bit(rt_bit),
            .lt_owns(lt_owns[i]), .rt_owns(rt_owns[i])
        );

        assert_single_holder_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !(lt_owns[i] && rt_owns[i]));

        assert_untouched_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!lt_we[i] && !rt_we[i]) |=> $stable(lt_owns[i]) && $stable(rt_owns[i]));
    end

endmodule

// File: tb/test_token_lock_bank.sv
module test_token_lock_bank;

    localparam logic [1:0] OP_I = 2'd0, OP_W = 2'd1, OP_R = 2'd2;
    localparam logic [8:0] ONES = 9'h1FF, ZERO = 9'h000;

    typedef struct packed {
        logic [1:0] lop;
        logic [2:0] la;
        logic [8:0] ld;
        logic [1:0] rop;
        logic [2:0] ra;
        logic [8:0] rd;
        logic [8:0] lexp;
        logic [8:0] rexp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{OP_R, 3'd0, 9'h000, OP_R, 3'd0, 9'h000, ONES, ONES, 4'd4},  // R4 free
        '{OP_W, 3'd0, 9'h000, OP_I, 3'd0, 9'h000, ONES, ONES, 4'd4},  // R4 left claims t0
        '{OP_R, 3'd0, 9'h000, OP_R, 3'd0, 9'h000, ZERO, ONES, 4'd7},  // R7 R4
        '{OP_R, 3'd1, 9'h000, OP_W, 3'd1, 9'h1FE, ONES, ONES, 4'd2},  // R2 t1 free; R3 claim
        '{OP_R, 3'd0, 9'h000, OP_R, 3'd1, 9'h000, ZERO, ZERO, 4'd3},  // R3 bit0 only
        '{OP_I, 3'd0, 9'h000, OP_W, 3'd0, 9'h000, ONES, ONES, 4'd5},  // R5 right queues
        '{OP_R, 3'd0, 9'h000, OP_R, 3'd0, 9'h000, ZERO, ONES, 4'd5},  // R5 still left
        '{OP_W, 3'd0, 9'h0FE, OP_I, 3'd0, 9'h000, ONES, ONES, 4'd11}, // R11 reclaim
        '{OP_R, 3'd0, 9'h000, OP_R, 3'd0, 9'h000, ZERO, ONES, 4'd11}, // R11
        '{OP_W, 3'd0, 9'h001, OP_I, 3'd0, 9'h000, ONES, ONES, 4'd5},  // R5 release
        '{OP_R, 3'd0, 9'h000, OP_R, 3'd0, 9'h000, ONES, ZERO, 4'd5},  // R5 hand-off
        '{OP_W, 3'd1, 9'h1FF, OP_I, 3'd0, 9'h000, ONES, ONES, 4'd6},  // R6 stray release
        '{OP_R, 3'd1, 9'h000, OP_R, 3'd1, 9'h000, ONES, ZERO, 4'd6},  // R6 no effect
        '{OP_W, 3'd2, 9'h000, OP_W, 3'd2, 9'h000, ONES, ONES, 4'd10}, // R10 tie
        '{OP_R, 3'd2, 9'h000, OP_R, 3'd2, 9'h000, ZERO, ONES, 4'd10}, // R10 left wins
        '{OP_W, 3'd2, 9'h001, OP_I, 3'd0, 9'h000, ONES, ONES, 4'd10}, // R10 release
        '{OP_R, 3'd2, 9'h000, OP_R, 3'd2, 9'h000, ONES, ZERO, 4'd10}, // R10 pending served
        '{OP_W, 3'd3, 9'h000, OP_W, 3'd0, 9'h001, ONES, ONES, 4'd9},  // R9 left first
        '{OP_I, 3'd0, 9'h000, OP_W, 3'd3, 9'h000, ONES, ONES, 4'd9},  // R9 right later
        '{OP_R, 3'd3, 9'h000, OP_R, 3'd3, 9'h000, ZERO, ONES, 4'd9},  // R9
        '{OP_R, 3'd0, 9'h000, OP_R, 3'd0, 9'h000, ONES, ONES, 4'd6},  // R6 t0 freed
        '{OP_I, 3'd0, 9'h000, OP_W, 3'd1, 9'h1FF, ONES, ONES, 4'd6},  // R6 own release
        '{OP_R, 3'd1, 9'h000, OP_R, 3'd1, 9'h000, ONES, ONES, 4'd6},  // R6
        '{OP_R, 3'd7, 9'h000, OP_R, 3'd5, 9'h000, ONES, ONES, 4'd2}   // R2 others untouched
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lt_sel = 0, lt_wr = 0, lt_oe = 0, rt_sel = 0, rt_wr = 0, rt_oe = 0;
    logic [2:0] lt_addr = 0, rt_addr = 0;
    logic [8:0] lt_wdata = 0, rt_wdata = 0;
    logic [8:0] lt_rdata, rt_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    token_lock_bank i_token_lock_bank (
        .clk(clk), .rst_n(rst_n),
        .lt_sel(lt_sel), .lt_wr(lt_wr), .lt_oe(lt_oe), .lt_addr(lt_addr),
        .lt_wdata(lt_wdata), .lt_rdata(lt_rdata),
        .rt_sel(rt_sel), .rt_wr(rt_wr), .rt_oe(rt_oe), .rt_addr(rt_addr),
        .rt_wdata(rt_wdata), .rt_rdata(rt_rdata)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [8:0] act, input logic [8:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive_lt(input logic [1:0] op, input logic [2:0] a, input logic [8:0] d);
        lt_sel = (op != OP_I); lt_wr = (op == OP_W); lt_oe = (op == OP_R);
        lt_addr = a; lt_wdata = d;
    endtask

    task automatic drive_rt(input logic [1:0] op, input logic [2:0] a, input logic [8:0] d);
        rt_sel = (op != OP_I); rt_wr = (op == OP_W); rt_oe = (op == OP_R);
        rt_addr = a; rt_wdata = d;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        // R1: reset read data
        check("R1", "left reset rdata", lt_rdata, ONES);
        check("R1", "right reset rdata", rt_rdata, ONES);

        for (int v = 0; v < NV; v++) begin
            drive_lt(VECS[v].lop, VECS[v].la, VECS[v].ld);
            drive_rt(VECS[v].rop, VECS[v].ra, VECS[v].rd);
            tick();
            if (VECS[v].lop == OP_R)
                check($sformatf("R%0d", VECS[v].req), $sformatf("vec %0d left", v),
                      lt_rdata, VECS[v].lexp);
            if (VECS[v].rop == OP_R)
                check($sformatf("R%0d", VECS[v].req), $sformatf("vec %0d right", v),
                      rt_rdata, VECS[v].rexp);
            drive_lt(OP_I, 3'd0, 9'h0);
            drive_rt(OP_I, 3'd0, 9'h0);
            tick();
        end

        // R8: right holds a read of t3 open while left hands t3 over
        drive_rt(OP_R, 3'd3, 9'h0);
        tick();
        check("R8", "right open read", rt_rdata, ONES);
        drive_lt(OP_W, 3'd3, 9'h001);
        tick();
        drive_lt(OP_I, 3'd0, 9'h0);
        tick(); tick();
        check("R8", "right frozen across hand-off", rt_rdata, ONES);
        rt_oe = 1'b0;
        tick();
        check("R8", "right idle keeps last value", rt_rdata, ONES);
        rt_oe = 1'b1;
        tick();
        check("R8", "right reread after drop", rt_rdata, ZERO);
        drive_rt(OP_I, 3'd0, 9'h0);
        tick();

        // R1: reset frees everything
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        drive_lt(OP_R, 3'd3, 9'h0);
        drive_rt(OP_R, 3'd3, 9'h0);
        tick();
        check("R1", "left t3 after reset", lt_rdata, ONES);
        check("R1", "right t3 after reset", rt_rdata, ONES);
        drive_lt(OP_I, 3'd0, 9'h0);
        drive_rt(OP_I, 3'd0, 9'h0);
        tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule